// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block interprets the bus writes that a host makes to a parallel NOR flash and decides when an array operation may start. A modifying command is accepted only after a fixed run of unlock writes. Each write is a pair of address and data values. A byte program needs three such writes before it: it is armed by the third write and issued by the fourth. The three erase types go through a six-write sequence. Any write that does not fit the expected step drops the decoder back to plain array read. A separate short sequence puts the decoder into an identification mode, in which reads return fixed code bytes.

The chip-enable, write-enable and output-enable levels arrive already sampled on the block clock. A write cycle is the interval in which chip enable and write enable are both low while output enable is high. The address is taken at the start of that interval. The data is taken at its end. An interval shorter than a parameterised number of clock cycles is discarded as a glitch. While the array reports busy, every write is ignored and the decoder is held in read mode.

The outputs are single-cycle start pulses, one for each operation. Each pulse comes with a registered operation address and data byte. There is also an identification-mode flag and a registered identification read byte.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all four start pulses are low, `id_mode` is low and `id_rdata` is 00h.
- R2: Unlock step one is data AAh with address bits 14..0 equal to AAAh. Step two is data 55h with address bits 14..0 equal to 555h. Address bits 19..15 are ignored during these command writes.
- R3: After the two unlock writes, a third write of A0h at AAAh arms programming. The next accepted write then raises `prog_start` for one cycle. `op_addr` and `op_data` carry that write's address and data. The pulse appears two clock edges after the edge that first samples the strobe released.
- R4: After the unlock, a third write of 80h at AAAh must be followed by AAh at AAAh and then 55h at 555h. The sixth write then selects the erase type. Data 10h at AAAh raises `chip_erase_start` with `op_addr` = 0. Data 30h raises `sect_erase_start` with `op_addr` = the write address with bits 11..0 cleared. Data 50h raises `blk_erase_start` with `op_addr` = the write address with bits 15..0 cleared.
- R5: A write that does not match the expected step returns the decoder to read. A later write that would only be valid mid-sequence starts nothing.
- R6: After the unlock, a third write of 90h at AAAh sets `id_mode`. While `id_mode` is high and chip enable and output enable are both low, `id_rdata` is registered one cycle later. It is 7Fh when address bits 14..0 are 0, 21h when they are 1, and 00h otherwise. When `id_mode` is low, `id_rdata` is 00h.
- R7: In identification mode, a write of F0h at any address clears `id_mode`. Any other write leaves it set.
- R8: The address is captured on the first cycle in which the write condition holds. The data is captured on the last such cycle.
- R9: A write condition lasting fewer than MIN_PULSE sampled cycles is not a write and leaves the sequence state unchanged. One lasting exactly MIN_PULSE cycles is a write.
- R10: While output enable is low, chip enable and write enable being low does not count as a write.
- R11: While `busy` is high, writes are ignored and the state is forced to read, which clears `id_mode`. No start pulse follows a cycle in which `busy` is high.
- R12: At most one start pulse is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| addr | input | 20 | Bus address |
| wdata | input | 8 | Bus write data |
| busy | input | 1 | Array operation in progress |
| prog_start | output | 1 | One-cycle byte program request |
| sect_erase_start | output | 1 | One-cycle sector erase request |
| blk_erase_start | output | 1 | One-cycle block erase request |
| chip_erase_start | output | 1 | One-cycle chip erase request |
| op_addr | output | 20 | Address belonging to the latest request |
| op_data | output | 8 | Data belonging to the latest request |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification read byte |

## Verification
The bench builds the decoder with MIN_PULSE set to 3. With that value, a two-cycle strobe sits just under the glitch threshold and a three-cycle strobe sits exactly on it, so both sides of the limit are tested without long waits. The same short strobe keeps every six-write erase sequence to a few dozen cycles. That leaves room for abort cases, upper-address don't-care cases, a moving address and data inside one strobe, and busy interruptions in both the program path and identification mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 8;
    localparam int CMP_W    = 15;
    localparam int NUM_OPS  = 4;
    localparam int SECT_LSB = 12;
    localparam int BLK_LSB  = 16;

    localparam logic [CMP_W-1:0]  ADR_KEY_A = 15'h0AAA;
    localparam logic [CMP_W-1:0]  ADR_KEY_B = 15'h0555;

    localparam logic [DATA_W-1:0] CD_KEY_A  = 8'hAA;
    localparam logic [DATA_W-1:0] CD_KEY_B  = 8'h55;
    localparam logic [DATA_W-1:0] CD_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] CD_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] CD_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] CD_LEAVE  = 8'hF0;
    localparam logic [DATA_W-1:0] CD_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] CD_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] CD_BLK    = 8'h50;

    localparam logic [DATA_W-1:0] ID_CODE0  = 8'h7F;
    localparam logic [DATA_W-1:0] ID_CODE1  = 8'h21;

    typedef enum logic [2:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PROG,
        ST_ERA3, ST_ERA4, ST_ERA5, ST_IDENT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic is_cmd(input bus_wr_t w,
                                    input logic [CMP_W-1:0] a,
                                    input logic [DATA_W-1:0] d);
        return (w.addr[CMP_W-1:0] == a) && (w.data == d);
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input int lsb);
        return a & ~((ADDR_W'(1) << lsb) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/fcd_strobe_qual.sv
module fcd_strobe_qual
    import fcd_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_valid,
    output bus_wr_t           wr_bus
);

    localparam int               CNT_W   = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

    logic             active;
    logic             act_q;
    logic [CNT_W-1:0] width_cnt;
    bus_wr_t          cap;
    logic             ends_ok;

    // write condition: selected, strobed, outputs not enabled
    assign active  = !ce_n && !we_n && oe_n;
    // a cycle ends only by a strobe rising, never by output enable falling
    assign ends_ok = act_q && !active && oe_n && (width_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            width_cnt <= '0;
            cap       <= '0;
            wr_valid  <= 1'b0;
            wr_bus    <= '0;
        end else begin
            act_q    <= active;
            wr_valid <= ends_ok;
            if (ends_ok) begin
                wr_bus <= cap;
            end
            if (active) begin
                cap.data <= wdata;
                if (!act_q) begin
                    cap.addr  <= addr;
                    width_cnt <= CNT_W'(1);
                end else if (width_cnt != CNT_MAX) begin
                    width_cnt <= width_cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               wr_valid,
    input  bus_wr_t            wr_bus,
    output logic [NUM_OPS-1:0] start_vec,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [DATA_W-1:0]  op_data,
    output logic               id_mode
);

    seq_state_t        st, st_nxt;
    logic              fire;
    op_kind_t          kind;
    logic [ADDR_W-1:0] tgt_addr;

    always_comb begin
        st_nxt   = st;
        fire     = 1'b0;
        kind     = OP_PROG;
        tgt_addr = wr_bus.addr;
        if (wr_valid) begin
            unique case (st)
                ST_READ: st_nxt = is_cmd(wr_bus, ADR_KEY_A, CD_KEY_A) ? ST_UNL1 : ST_READ;
                ST_UNL1: st_nxt = is_cmd(wr_bus, ADR_KEY_B, CD_KEY_B) ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    if (is_cmd(wr_bus, ADR_KEY_A, CD_PROG))       st_nxt = ST_PROG;
                    else if (is_cmd(wr_bus, ADR_KEY_A, CD_ERASE)) st_nxt = ST_ERA3;
                    else if (is_cmd(wr_bus, ADR_KEY_A, CD_IDENT)) st_nxt = ST_IDENT;
                    else                                          st_nxt = ST_READ;
                end
                ST_PROG: begin
                    fire   = 1'b1;
                    kind   = OP_PROG;
                    st_nxt = ST_READ;
                end
                ST_ERA3: st_nxt = is_cmd(wr_bus, ADR_KEY_A, CD_KEY_A) ? ST_ERA4 : ST_READ;
                ST_ERA4: st_nxt = is_cmd(wr_bus, ADR_KEY_B, CD_KEY_B) ? ST_ERA5 : ST_READ;
                ST_ERA5: begin
                    st_nxt = ST_READ;
                    if (is_cmd(wr_bus, ADR_KEY_A, CD_CHIP)) begin
                        fire     = 1'b1;
                        kind     = OP_CHIP;
                        tgt_addr = '0;
                    end else if (wr_bus.data == CD_SECT) begin
                        fire     = 1'b1;
                        kind     = OP_SECT;
                        tgt_addr = align_down(wr_bus.addr, SECT_LSB);
                    end else if (wr_bus.data == CD_BLK) begin
                        fire     = 1'b1;
                        kind     = OP_BLK;
                        tgt_addr = align_down(wr_bus.addr, BLK_LSB);
                    end
                end
                ST_IDENT: st_nxt = (wr_bus.data == CD_LEAVE) ? ST_READ : ST_IDENT;
                default:  st_nxt = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_READ;
            start_vec <= '0;
            op_addr   <= '0;
            op_data   <= '0;
        end else if (busy) begin
            st        <= ST_READ;
            start_vec <= '0;
        end else begin
            st        <= st_nxt;
            start_vec <= fire ? (NUM_OPS'(1) << kind) : '0;
            if (fire) begin
                op_addr <= tgt_addr;
                op_data <= wr_bus.data;
            end
        end
    end

    assign id_mode = (st == ST_IDENT);

endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              id_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [CMP_W-1:0]  offs,
    output logic [DATA_W-1:0] id_rdata
);

    logic [DATA_W-1:0] code;

    always_comb begin
        if (offs == CMP_W'(0))      code = ID_CODE0;
        else if (offs == CMP_W'(1)) code = ID_CODE1;
        else                        code = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) id_rdata <= '0;
        else     id_rdata <= (id_mode && !ce_n && !oe_n) ? code : '0;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata
);

    logic               wr_valid;
    bus_wr_t            wr_bus;
    logic [NUM_OPS-1:0] start_vec;

    fcd_strobe_qual #(.MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_valid(wr_valid),
        .wr_bus  (wr_bus)
    );

    fcd_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .wr_valid (wr_valid),
        .wr_bus   (wr_bus),
        .start_vec(start_vec),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .id_mode  (id_mode)
    );

    fcd_id_rom u_idrom (
        .clk     (clk),
        .rst     (rst),
        .id_mode (id_mode),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .offs    (addr[CMP_W-1:0]),
        .id_rdata(id_rdata)
    );

    assign prog_start       = start_vec[OP_PROG];
    assign sect_erase_start = start_vec[OP_SECT];
    assign blk_erase_start  = start_vec[OP_BLK];
    assign chip_erase_start = start_vec[OP_CHIP];

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              busy,
    input logic              prog_start,
    input logic              sect_erase_start,
    input logic              blk_erase_start,
    input logic              chip_erase_start,
    input logic [ADDR_W-1:0] op_addr,
    input logic              id_mode,
    input logic [DATA_W-1:0] id_rdata
);

    logic [3:0] starts;
    assign starts = {chip_erase_start, blk_erase_start, sect_erase_start, prog_start};

    assert_one_start_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(starts));

    assert_single_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (starts != 4'b0) |=> (starts == 4'b0));

    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!id_mode && (starts == 4'b0)));

    assert_idle_idread_R6: assert property (@(posedge clk) disable iff (rst)
        !id_mode |=> (id_rdata == '0));

    assert_sector_align_R4: assert property (@(posedge clk) disable iff (rst)
        sect_erase_start |-> (op_addr[SECT_LSB-1:0] == '0));

    assert_block_align_R4: assert property (@(posedge clk) disable iff (rst)
        blk_erase_start |-> (op_addr[BLK_LSB-1:0] == '0));

    assert_after_release_R8: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(ce_n || we_n || !oe_n, 2));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
    .clk             (clk),
    .rst             (rst),
    .ce_n            (ce_n),
    .we_n            (we_n),
    .oe_n            (oe_n),
    .busy            (busy),
    .prog_start      (prog_start),
    .sect_erase_start(sect_erase_start),
    .blk_erase_start (blk_erase_start),
    .chip_erase_start(chip_erase_start),
    .op_addr         (op_addr),
    .id_mode         (id_mode),
    .id_rdata        (id_rdata)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    localparam int MINP = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, we_n, oe_n, busy;
    logic [19:0] addr;
    logic [7:0]  wdata;
    logic        prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
    logic [19:0] op_addr;
    logic [7:0]  op_data;
    logic        id_mode;
    logic [7:0]  id_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    string cur_req = "R5";

    typedef struct {
        int         kind;
        logic [19:0] a;
        logic [7:0]  d;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    flash_cmd_decoder #(.MIN_PULSE(MINP)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .busy(busy),
        .prog_start(prog_start), .sect_erase_start(sect_erase_start),
        .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
        .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_op(input int kind, input logic [19:0] a,
                             input logic [7:0] d, input string req);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: every start pulse is popped and compared against the scoreboard
    always @(negedge clk) begin
        if (!rst && (prog_start || sect_erase_start || blk_erase_start || chip_erase_start)) begin
            int k;
            int nb;
            nb = int'(prog_start) + int'(sect_erase_start) + int'(blk_erase_start) + int'(chip_erase_start);
            k  = prog_start ? 0 : sect_erase_start ? 1 : blk_erase_start ? 2 : 3;
            chk(nb == 1, "R12", "start pulses in one cycle", nb, 1);
            if (sb.size() == 0) begin
                chk(0, cur_req, "unexpected start kind", k, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(k == e.kind, e.req, "start kind", k, e.kind);
                chk(op_addr == e.a, e.req, "op_addr", op_addr, e.a);
                chk(op_data == e.d, e.req, "op_data", op_data, e.d);
            end
        end
    end

    task automatic bus_wr(input logic [19:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        addr = a; wdata = d;
        ce_n = 1'b0; we_n = 1'b0;
        repeat (width) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock3(input logic [7:0] cmd);
        bus_wr(20'h00AAA, 8'hAA, MINP);
        bus_wr(20'h00555, 8'h55, MINP);
        bus_wr(20'h00AAA, cmd, MINP);
    endtask

    task automatic erase6(input logic [19:0] a, input logic [7:0] d);
        unlock3(8'h80);
        bus_wr(20'h00AAA, 8'hAA, MINP);
        bus_wr(20'h00555, 8'h55, MINP);
        bus_wr(a, d, MINP);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, cur_req, "pending expected starts", sb.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; busy = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        chk(!prog_start && !sect_erase_start && !blk_erase_start && !chip_erase_start,
            "R1", "starts after reset", 0, 0);
        chk(id_mode == 1'b0, "R1", "id_mode after reset", id_mode, 0);
        chk(id_rdata == 8'h00, "R1", "id_rdata after reset", id_rdata, 0);

        // R3 plain byte program
        cur_req = "R3";
        unlock3(8'hA0);
        expect_op(0, 20'h12345, 8'h5A, "R3");
        bus_wr(20'h12345, 8'h5A, MINP);
        settle();

        // R2 upper address bits ignored in command writes
        cur_req = "R2";
        bus_wr(20'hF8AAA, 8'hAA, MINP);
        bus_wr(20'h38555, 8'h55, MINP);
        bus_wr(20'hA0AAA, 8'hA0, MINP);
        expect_op(0, 20'hFFFFF, 8'h00, "R2");
        bus_wr(20'hFFFFF, 8'h00, MINP);
        settle();

        // R4 sector, block and chip erase
        cur_req = "R4";
        expect_op(1, 20'hAB000, 8'h30, "R4");
        erase6(20'hABCDE, 8'h30);
        settle();
        expect_op(2, 20'h70000, 8'h50, "R4");
        erase6(20'h7FFFF, 8'h50);
        settle();
        expect_op(3, 20'h00000, 8'h10, "R4");
        erase6(20'h80AAA, 8'h10);
        settle();

        // R5 mismatch on step two, then a would-be program write starts nothing
        cur_req = "R5";
        bus_wr(20'h00AAA, 8'hAA, MINP);
        bus_wr(20'h00555, 8'h56, MINP);
        bus_wr(20'h00AAA, 8'hA0, MINP);
        bus_wr(20'h00100, 8'h33, MINP);
        settle();
        // R5 mismatch in the erase tail, final erase code is dropped
        bus_wr(20'h00AAA, 8'hAA, MINP);
        bus_wr(20'h00555, 8'h55, MINP);
        bus_wr(20'h00AAA, 8'h80, MINP);
        bus_wr(20'h00555, 8'hAA, MINP);
        bus_wr(20'h00555, 8'h55, MINP);
        bus_wr(20'h40000, 8'h30, MINP);
        settle();

        // R9 a short strobe on step two is no write; state stays at step two
        cur_req = "R9";
        bus_wr(20'h00AAA, 8'hAA, MINP);
        bus_wr(20'h00123, 8'h99, MINP - 1);
        bus_wr(20'h00555, 8'h55, MINP);
        bus_wr(20'h00AAA, 8'hA0, MINP);
        expect_op(0, 20'h00321, 8'hC3, "R9");
        bus_wr(20'h00321, 8'hC3, MINP);
        settle();
        // R9 a short strobe as the program write does not fire
        unlock3(8'hA0);
        bus_wr(20'h00400, 8'h11, MINP - 1);
        settle();
        expect_op(0, 20'h00401, 8'h22, "R9");
        bus_wr(20'h00401, 8'h22, MINP);
        settle();

        // R10 output enable low blocks the program write
        cur_req = "R10";
        unlock3(8'hA0);
        @(negedge clk);
        oe_n = 1'b0;
        bus_wr(20'h00500, 8'h44, MINP);
        oe_n = 1'b1;
        settle();
        expect_op(0, 20'h00501, 8'h45, "R10");
        bus_wr(20'h00501, 8'h45, MINP);
        settle();

        // R8 address taken at strobe start, data at strobe end
        cur_req = "R8";
        unlock3(8'hA0);
        @(negedge clk);
        addr = 20'h0BEEF; wdata = 8'h00;
        we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        addr = 20'h00DEA; wdata = 8'h17;
        @(negedge clk);
        wdata = 8'h5A;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        expect_op(0, 20'h0BEEF, 8'h5A, "R8");
        repeat (3) @(negedge clk);
        settle();

        // R6 identification mode reads
        cur_req = "R6";
        unlock3(8'h90);
        chk(id_mode == 1'b1, "R6", "id_mode after entry", id_mode, 1);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = 20'h00000;
        repeat (2) @(negedge clk);
        chk(id_rdata == 8'h7F, "R6", "id read offset 0", id_rdata, 8'h7F);
        addr = 20'h00001;
        repeat (2) @(negedge clk);
        chk(id_rdata == 8'h21, "R6", "id read offset 1", id_rdata, 8'h21);
        addr = 20'h00002;
        repeat (2) @(negedge clk);
        chk(id_rdata == 8'h00, "R6", "id read offset 2", id_rdata, 0);
        ce_n = 1'b1; oe_n = 1'b1;

        // R7 other writes keep the mode, exit code clears it
        cur_req = "R7";
        bus_wr(20'h00AAA, 8'hAA, MINP);
        chk(id_mode == 1'b1, "R7", "id_mode after non-exit write", id_mode, 1);
        bus_wr(20'h3C123, 8'hF0, MINP);
        chk(id_mode == 1'b0, "R7", "id_mode after exit write", id_mode, 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = 20'h00000;
        repeat (2) @(negedge clk);
        chk(id_rdata == 8'h00, "R6", "id read outside id mode", id_rdata, 0);
        ce_n = 1'b1; oe_n = 1'b1;

        // R11 busy drops an armed program and ignores writes
        cur_req = "R11";
        unlock3(8'hA0);
        @(negedge clk);
        busy = 1'b1;
        bus_wr(20'h00600, 8'h66, MINP);
        busy = 1'b0;
        bus_wr(20'h00601, 8'h67, MINP);
        settle();
        // R11 busy clears identification mode
        unlock3(8'h90);
        chk(id_mode == 1'b1, "R11", "id_mode before busy", id_mode, 1);
        @(negedge clk);
        busy = 1'b1;
        @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        chk(id_mode == 1'b0, "R11", "id_mode after busy", id_mode, 0);

        // R12 back-to-back operations each produce one single pulse
        cur_req = "R12";
        unlock3(8'hA0);
        expect_op(0, 20'h00777, 8'h77, "R12");
        bus_wr(20'h00777, 8'h77, MINP);
        chk(!prog_start, "R12", "prog_start after pulse", prog_start, 0);
        expect_op(3, 20'h00000, 8'h10, "R12");
        erase6(20'h00AAA, 8'h10);
        settle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule